// File: doc/BRIEF.md
# Two-Destination Predicate Compare Unit

This block evaluates one integer comparison between two general-register operands and turns the single boolean outcome into writes for a small set of predicate destinations. Two destinations are the default. Each destination carries its own 3-bit action code. The code chooses a sense (the outcome or its inverse) and a write class. The classes are always-write, write-when-guarded, accumulate-towards-one and accumulate-towards-zero. A guard predicate qualifies the whole operation.

The caller supplies the current value of every destination alongside the operation. The unit returns three things per destination: a write-enable, the value to write, and the merged next value (the written value, or the current value when nothing is written). A predicate file can therefore either use the enable and value pair or take the merged value as is. By default the result is registered, one cycle after issue. The storage of the predicates and the decoding of instructions sit outside the block.

Top module: `pcmp_unit`

## Requirements
- R1: `rel_i` selects the relation of `src_a_i` to `src_b_i`: 0 equal, 1 not equal, 2 signed less, 3 signed less-or-equal, 4 signed greater, 5 signed greater-or-equal, 6 unsigned less, 7 unsigned greater-or-equal.
- R2: An action code with bits [2:1]=00 always writes its destination. The value written is the guard ANDed with the sensed outcome. The sensed outcome is the compare result, inverted when action bit 0 is 1, so code 0 writes the result and code 1 writes its inverse.
- R3: Bits [2:1]=01 (codes 2, 3) write the sensed outcome only when the guard is 1. With the guard at 0 they write nothing.
- R4: Bits [2:1]=10 (codes 4, 5) write 1 only when the guard is 1 and the sensed outcome is 1. Otherwise they write nothing.
- R5: Bits [2:1]=11 (codes 6, 7) write 0 only when the guard is 1 and the sensed outcome is 0. Otherwise they write nothing.
- R6: Destination d takes its action from `act_i[3d+2:3d]`. Each destination is resolved on its own, from the same compare outcome.
- R7: While `valid_i` is 0, no destination is written, whatever the other inputs are.
- R8: `val_o[d]` is 0 whenever `wen_o[d]` is 0. `nxt_o[d]` equals `val_o[d]` when written and the sampled `cur_i[d]` otherwise.
- R9: With the default registered output, the results of an operation presented at one rising edge appear after that edge. Reset clears all outputs.
- R10: Signed and unsigned relations differ correctly at the operand extremes (most negative, most positive, all ones, zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| valid_i | input | 1 | an operation is issued this cycle |
| rel_i | input | 3 | relation selector |
| src_a_i | input | WIDTH | left operand |
| src_b_i | input | WIDTH | right operand |
| guard_i | input | 1 | guarding predicate |
| act_i | input | 3*NDST | per-destination action codes |
| cur_i | input | NDST | current destination values |
| wen_o | output | NDST | per-destination write enable |
| val_o | output | NDST | per-destination write value |
| nxt_o | output | NDST | per-destination merged next value |

## Verification
Boundary operand pairs run through all eight relations. These pairs are equal values, neighbours, and sign-extreme mixes such as most-negative against most-positive and all-ones against one. They separate a signed ordering from an unsigned one, and a strict relation from an inclusive one. All eight action codes are then swept against both guard values and both compare outcomes, with the two destinations given different codes. This shows whether a class confuses guard-gating with outcome-gating and whether the destinations stay independent. Long random runs mix idle cycles and random current values, which exposes a merge that ignores the current value or an enable that leaks while idle.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
   localparam int REL_W = 3;
   localparam int ACT_W = 3;

   typedef enum logic [REL_W-1:0] {
      REL_EQ  = 3'd0,
      REL_NE  = 3'd1,
      REL_SLT = 3'd2,
      REL_SLE = 3'd3,
      REL_SGT = 3'd4,
      REL_SGE = 3'd5,
      REL_ULT = 3'd6,
      REL_UGE = 3'd7
   } rel_e;

   typedef enum logic [1:0] {
      CLS_ALWAYS = 2'd0,
      CLS_GUARD  = 2'd1,
      CLS_ANY    = 2'd2,
      CLS_ALL    = 2'd3
   } cls_e;

   typedef struct packed {
      logic wen;
      logic val;
      logic nxt;
   } pwr_t;
endpackage

// File: rtl/pcmp_relation.sv
module pcmp_relation
   import pcmp_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter bit SUB_CMP = 1'b1
) (
   input  logic [REL_W-1:0] rel_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             res_o
);
   localparam int MSB = WIDTH - 1;

   logic eq, ltu, lts;

   assign eq = (a_i == b_i);

   generate
      if (SUB_CMP) begin : g_sub
         logic [WIDTH:0] diff;
         assign diff = {1'b0, a_i} - {1'b0, b_i};
         assign ltu  = diff[WIDTH];
         assign lts  = (a_i[MSB] ^ b_i[MSB]) ? a_i[MSB] : ltu;
      end else begin : g_native
         assign ltu = (a_i < b_i);
         assign lts = ($signed(a_i) < $signed(b_i));
      end
   endgenerate

   always_comb begin
      unique case (rel_e'(rel_i))
         REL_EQ:  res_o = eq;
         REL_NE:  res_o = !eq;
         REL_SLT: res_o = lts;
         REL_SLE: res_o = lts | eq;
         REL_SGT: res_o = !(lts | eq);
         REL_SGE: res_o = !lts;
         REL_ULT: res_o = ltu;
         REL_UGE: res_o = !ltu;
         default: res_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/pcmp_action.sv
module pcmp_action
   import pcmp_pkg::*;
(
   input  logic             issue_i,
   input  logic [ACT_W-1:0] act_i,
   input  logic             guard_i,
   input  logic             res_i,
   input  logic             cur_i,
   output pwr_t             wr_o
);
   logic sensed;
   logic wen_raw, val_raw;
   cls_e cls;

   assign cls    = cls_e'(act_i[2:1]);
   assign sensed = res_i ^ act_i[0];

   always_comb begin
      unique case (cls)
         CLS_ALWAYS: begin wen_raw = 1'b1;              val_raw = guard_i & sensed; end
         CLS_GUARD:  begin wen_raw = guard_i;           val_raw = sensed;           end
         CLS_ANY:    begin wen_raw = guard_i & sensed;  val_raw = 1'b1;             end
         CLS_ALL:    begin wen_raw = guard_i & !sensed; val_raw = 1'b0;             end
         default:    begin wen_raw = 1'b0;              val_raw = 1'b0;             end
      endcase
   end

   assign wr_o.wen = issue_i & wen_raw;
   assign wr_o.val = wr_o.wen & val_raw;
   assign wr_o.nxt = wr_o.wen ? val_raw : cur_i;
endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit
   import pcmp_pkg::*;
#(
   parameter int WIDTH   = 32,
   parameter int NDST    = 2,
   parameter bit OUT_REG = 1'b1,
   parameter bit SUB_CMP = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  valid_i,
   input  logic [REL_W-1:0]      rel_i,
   input  logic [WIDTH-1:0]      src_a_i,
   input  logic [WIDTH-1:0]      src_b_i,
   input  logic                  guard_i,
   input  logic [NDST*ACT_W-1:0] act_i,
   input  logic [NDST-1:0]       cur_i,
   output logic [NDST-1:0]       wen_o,
   output logic [NDST-1:0]       val_o,
   output logic [NDST-1:0]       nxt_o
);
   localparam int MAX_DST = 4;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("pcmp_unit: WIDTH must be at least 2");
      end
      if (NDST < 1 || NDST > MAX_DST) begin : g_bad_ndst
         $error("pcmp_unit: NDST must lie in 1..4");
      end
   endgenerate

   logic            res;
   logic [NDST-1:0] wen_c, val_c, nxt_c;

   pcmp_relation #(.WIDTH(WIDTH), .SUB_CMP(SUB_CMP)) u_rel (
      .rel_i (rel_i),
      .a_i   (src_a_i),
      .b_i   (src_b_i),
      .res_o (res)
   );

   generate
      for (genvar d = 0; d < NDST; d++) begin : g_dst
         pwr_t wr;
         pcmp_action u_act (
            .issue_i (valid_i),
            .act_i   (act_i[d*ACT_W +: ACT_W]),
            .guard_i (guard_i),
            .res_i   (res),
            .cur_i   (cur_i[d]),
            .wr_o    (wr)
         );
         assign wen_c[d] = wr.wen;
         assign val_c[d] = wr.val;
         assign nxt_c[d] = wr.nxt;
      end
   endgenerate

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wen_o <= '0;
               val_o <= '0;
               nxt_o <= '0;
            end else begin
               wen_o <= wen_c;
               val_o <= val_c;
               nxt_o <= nxt_c;
            end
         end

         // R7
         idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_i |=> (wen_o == '0));

         for (genvar d = 0; d < NDST; d++) begin : g_chk
            localparam int CH = d*ACT_W + 2;
            localparam int SB = d*ACT_W;

            // R2
            always_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_i && act_i[CH -: 2] == 2'b00) |=> wen_o[d]);
            // R2
            always_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_i && !guard_i && act_i[CH -: 2] == 2'b00) |=> !val_o[d]);
            // R3
            guard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_i && !guard_i && act_i[CH -: 2] != 2'b00) |=> !wen_o[d]);
            // R4
            any_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_i && act_i[CH -: 2] == 2'b10) |=> (!wen_o[d] || val_o[d]));
            // R5
            all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_i && act_i[CH -: 2] == 2'b11) |=> !val_o[d]);
            // R8
            hold_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
               !valid_i |=> (nxt_o[d] == $past(cur_i[d])));
            // R6
            sense_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (valid_i && guard_i && act_i[CH -: 2] == 2'b00 && act_i[SB] == 1'b0)
               |=> (nxt_o[d] == val_o[d]));
         end
      end else begin : g_comb
         assign wen_o = wen_c;
         assign val_o = val_c;
         assign nxt_o = nxt_c;
      end
   endgenerate
endmodule

// File: tb/pcmp_unit_tb.sv
module pcmp_unit_tb;
   localparam int W  = 32;
   localparam int ND = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_i = 1'b0;
   logic [2:0]    rel_i = '0;
   logic [W-1:0]  src_a_i = '0, src_b_i = '0;
   logic          guard_i = 1'b0;
   logic [ND*3-1:0] act_i = '0;
   logic [ND-1:0] cur_i = '0;
   logic [ND-1:0] wen_o, val_o, nxt_o;

   int checks = 0;
   int errors = 0;
   logic [ND-1:0] e_wen = '0, e_val = '0, e_nxt = '0;
   string e_tag = "R9";
   string phase = "";
   bit    done = 1'b0;

   always #4 clk = ~clk;

   pcmp_unit u_dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .rel_i(rel_i),
      .src_a_i(src_a_i), .src_b_i(src_b_i), .guard_i(guard_i),
      .act_i(act_i), .cur_i(cur_i), .wen_o(wen_o), .val_o(val_o), .nxt_o(nxt_o)
   );

   function automatic bit ref_cmp(input logic [2:0] r, input logic [W-1:0] a, input logic [W-1:0] b);
      longint sa, sb;
      longint unsigned ua, ub;
      sa = longint'($signed(a)); sb = longint'($signed(b));
      ua = longint'(a); ub = longint'(b);
      case (r)
         3'd0: return ua == ub;
         3'd1: return ua != ub;
         3'd2: return sa <  sb;
         3'd3: return sa <= sb;
         3'd4: return sa >  sb;
         3'd5: return sa >= sb;
         3'd6: return ua <  ub;
         default: return ua >= ub;
      endcase
   endfunction

   task automatic compare();
      for (int d = 0; d < ND; d++) begin
         checks++;
         if (wen_o[d] !== e_wen[d] || val_o[d] !== e_val[d] || nxt_o[d] !== e_nxt[d]) begin
            errors++;
            $display("FAIL %s dst%0d actual wen/val/nxt=%b%b%b expected=%b%b%b",
                     e_tag, d, wen_o[d], val_o[d], nxt_o[d], e_wen[d], e_val[d], e_nxt[d]);
         end
      end
   endtask

   task automatic step(input bit v, input logic [2:0] r, input logic [W-1:0] a,
                       input logic [W-1:0] b, input bit g, input logic [ND*3-1:0] ac,
                       input logic [ND-1:0] cu);
      bit res, s, w, val;
      int cls;
      @(negedge clk);
      compare();
      valid_i = v; rel_i = r; src_a_i = a; src_b_i = b; guard_i = g; act_i = ac; cur_i = cu;
      res = ref_cmp(r, a, b);
      for (int d = 0; d < ND; d++) begin
         cls = int'(ac[d*3+1 +: 2]);
         s = res ^ ac[d*3];
         case (cls)
            0: begin w = 1'b1;    val = g & s; end
            1: begin w = g;       val = s;     end
            2: begin w = g & s;   val = 1'b1;  end
            default: begin w = g & !s; val = 1'b0; end
         endcase
         if (!v) w = 1'b0;
         e_wen[d] = w;
         e_val[d] = w & val;
         e_nxt[d] = w ? val : cu[d];
      end
      if (phase != "") e_tag = phase;
      else if (!v) e_tag = "R7";
      else begin
         case (int'(ac[2:1]))
            0: e_tag = "R2";
            1: e_tag = "R3";
            2: e_tag = "R4";
            default: e_tag = "R5";
         endcase
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog actual=timeout expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [W-1:0] bv [7];
      bv[0] = '0; bv[1] = 32'd1; bv[2] = 32'd2; bv[3] = 32'h8000_0000;
      bv[4] = 32'h7FFF_FFFF; bv[5] = '1; bv[6] = 32'h8000_0001;
      // R9: reset state
      repeat (2) @(negedge clk);
      e_tag = "R9"; compare();
      rst_n = 1'b1;
      phase = "R9";
      step(1, 3'd0, 5, 5, 1, 6'b000_000, 2'b00);
      // R1 and R10: every relation over boundary pairs
      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++) begin
               phase = (i >= 3 || j >= 3) ? "R10" : "R1";
               step(1, 3'(r), bv[i], bv[j], 1, 6'b001_000, 2'b10);
            end
      // R6: independent actions on both destinations, all guard/outcome combos
      phase = "R6";
      for (int a0 = 0; a0 < 8; a0++)
         for (int a1 = 0; a1 < 8; a1++)
            for (int g = 0; g < 2; g++)
               for (int o = 0; o < 2; o++)
                  step(1, 3'd0, 7, o ? 32'd7 : 32'd9, g[0], {3'(a1), 3'(a0)}, 2'(a0 + g));
      // R7: idle cycles must not write, R8 merge holds current value
      phase = "R7";
      for (int k = 0; k < 8; k++) step(0, 3'(k), 1, 1, 1, 6'(k * 9), 2'(k));
      // R2..R5 and R8 over random traffic
      phase = "";
      for (int k = 0; k < 4000; k++)
         step(($urandom % 5) != 0, 3'($urandom), $urandom % 4 == 0 ? bv[$urandom % 7] : W'($urandom),
              $urandom % 3 == 0 ? 32'd7 : W'($urandom), 1'($urandom), 6'($urandom), 2'($urandom));
      phase = "R8";
      for (int k = 0; k < 4; k++) step(1, 3'd1, 3, 3, 1, 6'b100_101, 2'(k));
      step(0, 3'd0, 0, 0, 0, 6'b0, 2'b00);
      @(negedge clk); compare();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule